// File: doc/BRIEF.md
# Masked Pending Interrupt Register

This block collects event pulses from a serial bus remote terminal into a 16-bit set of sticky pending flags. Each flag stays set until the host clears it. A host-writable mask selects which flags reach the two interrupt lines. Flags for failures (bits 15 to 12) drive one line. Flags for message events (bits 11 to 7) drive the other. Bits 6 to 0 have no function.

The host reads the flags through a simple single-cycle register port. A read of the pending word does not clear it. The clear happens at the end of the next host access of any kind, to any address. That access still returns the data it addresses as it was before the clear. An event that arrives in the same cycle as the clear is kept. A pending address-parity failure also keeps the terminal's execution enable low.

Top module: `irq_pend_reg`

## Requirements
- R1: A one-cycle high on `evt_i[k]` for k in 7..15 sets pending bit k after the next rising clock edge, and the bit stays set until a deferred clear. Bit 15 is DMA fail, 14 wrap fail, 13 terminal address parity fail, 12 self-test fail, 11 message error, 10 subaddress accessed, 9 broadcast received, 8 index reached zero, 7 illegal command.
- R2: Pending bits 6..0 and mask bits 6..0 always read as 0, and events on `evt_i[6:0]` have no effect.
- R3: The mask register sits at address `MASK_ADDR`. A write stores `wdata_i` masked to bits 15..7, and a read returns the stored value. A mask bit of 1 enables the matching interrupt.
- R4: `fail_irq_o` is a level equal to the OR over bits 15..12 of (pending AND mask).
- R5: `msg_irq_o` is a level equal to the OR over bits 11..7 of (pending AND mask).
- R6: A read at `PEND_ADDR` (`sel_i`=1, `wr_i`=0) returns the pending word combinationally in the same cycle. The read itself does not clear the word.
- R7: After a pending read, the next access (`sel_i`=1, any address, read or write) clears the pending word at the end of that access. That access returns the pre-clear data. If that access is itself a pending read, it arms a new deferred clear.
- R8: An access that does not follow a pending read leaves the pending word unchanged. A write to `PEND_ADDR` never changes the pending bits.
- R9: An event asserted in the same cycle as a deferred clear is set in the pending word after that clock edge.
- R10: `exec_en_o` equals `run_i` AND NOT pending bit 13.
- R11: After reset, the pending word, the mask and the clear arm are all zero. `rdata_o` is 0 whenever there is no read of a mapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event pulses, one per pending bit position |
| run_i | input | 1 | Execution request from the terminal controller |
| sel_i | input | 1 | Host access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host register address |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid in the access cycle |
| fail_irq_o | output | 1 | Failure-class interrupt level |
| msg_irq_o | output | 1 | Message-class interrupt level |
| exec_en_o | output | 1 | Execution enable, gated by address parity failure |

## Verification
The bench builds the block with a 3-bit address, the mask at address 3 and the pending word at address 6. Random host accesses then often land on unmapped addresses. This checks that any access, including one that decodes to nothing, completes a deferred clear and reads back zero. The small address space also makes back-to-back pending reads common, which exercises the re-arm rule. Events on the same cycle as a clear occur both in a directed case and in the random traffic.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned FAIL_HI = 15;
    localparam int unsigned FAIL_LO = 12;
    localparam int unsigned MSG_HI  = 11;
    localparam int unsigned MSG_LO  = 7;
    localparam int unsigned TAPF_BIT = 13;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t USED_BITS = word_t'((1 << (FAIL_HI + 1)) - (1 << MSG_LO));

    function automatic logic group_any(input word_t pend, input word_t mask,
                                       input int unsigned hi, input int unsigned lo);
        logic acc;
        acc = 1'b0;
        for (int unsigned i = lo; i <= hi; i++) begin
            acc = acc | (pend[i] & mask[i]);
        end
        return acc;
    endfunction
endpackage

// File: rtl/irq_host_port.sv
module irq_host_port #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned MASK_ADDR = 3,
    parameter int unsigned PEND_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              mask_we_o,
    output logic              mask_rd_o,
    output logic              pend_rd_o,
    output logic              pend_wr_o,
    output logic              clr_o
);
    typedef struct packed {
        logic arm;
    } port_state_t;

    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADDR);

    port_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mask_we_o = sel_i &  wr_i & (addr_i == MASK_A);
        mask_rd_o = sel_i & ~wr_i & (addr_i == MASK_A);
        pend_rd_o = sel_i & ~wr_i & (addr_i == PEND_A);
        pend_wr_o = sel_i &  wr_i & (addr_i == PEND_A);
        clr_o     = sel_i & s_q.arm;
        if (sel_i) begin
            s_d.arm = pend_rd_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_CLEAR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> sel_i) else $error("clear without access"); // R8
    AST_ARM_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd_o ##1 sel_i |-> clr_o) else $error("armed clear missing"); // R7
    AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i && !pend_rd_o ##1 sel_i |-> !clr_o) else $error("clear while unarmed"); // R8
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t evt_i,
    input  logic  clr_i,
    output word_t pend_o
);
    typedef struct packed {
        word_t pend;
    } pend_state_t;

    pend_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.pend = '0;
        end
        s_d.pend = (s_d.pend | evt_i) & USED_BITS;
        pend_o   = s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[MSG_LO-1:0] == '0) else $error("unused pending bit set"); // R2
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & USED_BITS) |=> ((pend_o & $past(evt_i & USED_BITS)) == $past(evt_i & USED_BITS)))
        else $error("event lost"); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)))
        else $error("pending bit dropped without clear"); // R1
endmodule

// File: rtl/irq_mask.sv
module irq_mask
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  word_t wdata_i,
    output word_t mask_o
);
    typedef struct packed {
        word_t mask;
    } mask_state_t;

    mask_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.mask = wdata_i & USED_BITS;
        end
        mask_o = s_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_o)) else $error("mask changed without write"); // R3
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned MASK_ADDR = 3,
    parameter int unsigned PEND_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       evt_i,
    input  logic              run_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [15:0]       wdata_i,
    output logic [15:0]       rdata_o,
    output logic              fail_irq_o,
    output logic              msg_irq_o,
    output logic              exec_en_o
);
    logic  mask_we, mask_rd, pend_rd, pend_wr, clr;
    word_t pend, mask;

    irq_host_port #(
        .ADDR_W   (ADDR_W),
        .MASK_ADDR(MASK_ADDR),
        .PEND_ADDR(PEND_ADDR)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel_i),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .mask_we_o(mask_we),
        .mask_rd_o(mask_rd),
        .pend_rd_o(pend_rd),
        .pend_wr_o(pend_wr),
        .clr_o    (clr)
    );

    irq_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (clr),
        .pend_o(pend)
    );

    irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mask_we),
        .wdata_i(wdata_i),
        .mask_o (mask)
    );

    always_comb begin
        rdata_o = '0;
        if (pend_rd) begin
            rdata_o = pend;
        end else if (mask_rd) begin
            rdata_o = mask;
        end
        fail_irq_o = group_any(pend, mask, FAIL_HI, FAIL_LO);
        msg_irq_o  = group_any(pend, mask, MSG_HI, MSG_LO);
        exec_en_o  = run_i & ~pend[TAPF_BIT];
    end

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!fail_irq_o && !msg_irq_o)) else $error("irq while fully masked"); // R4
    AST_IRQ_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!fail_irq_o && !msg_irq_o)) else $error("irq with nothing pending"); // R5
    AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pend == $past(evt_i & USED_BITS))) else $error("deferred clear incomplete"); // R7
    AST_PEND_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr && !clr |=> ((pend & $past(pend)) == $past(pend))) else $error("pending write altered bits"); // R8
    AST_PARITY_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pend[TAPF_BIT] |-> !exec_en_o) else $error("run enabled with parity fail"); // R10
endmodule

// File: tb/test_irq_pend_reg.sv
`timescale 1ns/1ps
module test_irq_pend_reg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned MADR   = 3;
    localparam int unsigned PADR   = 6;
    localparam logic [15:0] USED   = 16'hFF80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       evt_i = '0;
    logic              run_i = 1'b0;
    logic              sel_i = 1'b0;
    logic              wr_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [15:0]       wdata_i = '0;
    logic [15:0]       rdata_o;
    logic              fail_irq_o, msg_irq_o, exec_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_pend = '0, m_mask = '0;
    bit m_arm = 0;

    always #2.5 clk = ~clk;

    irq_pend_reg #(.ADDR_W(ADDR_W), .MASK_ADDR(MADR), .PEND_ADDR(PADR)) i_irq_pend_reg (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .run_i(run_i), .sel_i(sel_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .fail_irq_o(fail_irq_o), .msg_irq_o(msg_irq_o), .exec_en_o(exec_en_o)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    function automatic logic grp(input logic [15:0] p, input logic [15:0] m, input int hi, input int lo);
        logic r = 1'b0;
        for (int i = lo; i <= hi; i++) r = r | (p[i] & m[i]);
        return r;
    endfunction

    function automatic logic [15:0] exp_rd(input bit s, input bit w, input int a);
        if (!s || w) return 16'h0000;
        if (a == PADR) return m_pend;
        if (a == MADR) return m_mask;
        return 16'h0000;
    endfunction

    // Drive one cycle at the falling edge, check, update model, wait for next falling edge.
    task automatic step(input logic [15:0] evt, input bit s, input bit w, input int a,
                        input logic [15:0] wd, input bit run, input string tag);
        evt_i = evt; sel_i = s; wr_i = w; addr_i = ADDR_W'(a); wdata_i = wd; run_i = run;
        #1;
        chk({15'd0, fail_irq_o}, {15'd0, grp(m_pend, m_mask, 15, 12)}, "R4", "fail_irq");
        chk({15'd0, msg_irq_o},  {15'd0, grp(m_pend, m_mask, 11, 7)},  "R5", "msg_irq");
        chk({15'd0, exec_en_o},  {15'd0, run & ~m_pend[13]},            "R10", "exec_en");
        chk(rdata_o, exp_rd(s, w, a), tag, "rdata");
        begin
            bit clr = s & m_arm;
            if (s && w && a == MADR) m_mask = wd & USED;
            m_pend = ((clr ? 16'h0 : m_pend) | evt) & USED;
            if (s) m_arm = (!w && a == PADR);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        step(16'h0, 1, 0, PADR, 0, 0, "R11");
        step(16'h0, 1, 0, MADR, 0, 0, "R11");
        // R3: mask write and readback, unused bits dropped
        step(16'h0, 1, 1, MADR, 16'hFFFF, 0, "R3");
        step(16'h0, 1, 0, MADR, 0, 0, "R3");
        // R2: low events ignored
        step(16'h007F, 0, 0, 0, 0, 0, "R2");
        step(16'h0, 1, 0, PADR, 0, 0, "R2");
        step(16'h0, 1, 0, MADR, 0, 0, "R2");
        // R1/R6/R7: subaddress event, read, other access, read again
        step(16'h0400, 0, 0, 0, 0, 1, "R1");
        step(16'h0, 1, 0, PADR, 0, 1, "R6");
        step(16'h0, 0, 0, 0, 0, 1, "R6");
        step(16'h0, 1, 0, MADR, 0, 1, "R7");
        step(16'h0, 1, 0, PADR, 0, 1, "R7");
        // R7: unmapped write also clears
        step(16'h8000, 1, 1, 0, 16'h1234, 1, "R7");
        step(16'h0, 1, 0, PADR, 0, 1, "R7");
        step(16'h0, 1, 1, 5, 0, 1, "R7");
        step(16'h0, 1, 0, PADR, 0, 1, "R7");
        // R9: event in the clearing cycle survives
        step(16'h0, 1, 0, MADR, 0, 1, "R9");
        step(16'h8000, 0, 0, 0, 0, 1, "R9");
        step(16'h0, 1, 0, PADR, 0, 1, "R9");
        step(16'h0100, 1, 0, MADR, 0, 1, "R9");
        step(16'h0, 1, 0, PADR, 0, 1, "R9");
        // R8/R10: write to pending ignored; parity fail blocks run
        step(16'h0, 1, 0, MADR, 0, 1, "R8");
        step(16'h2000, 0, 0, 0, 0, 1, "R10");
        step(16'h0, 1, 1, PADR, 16'h0000, 1, "R8");
        step(16'h0, 1, 1, MADR, 16'h0000, 1, "R8");
        step(16'h0, 1, 0, PADR, 0, 1, "R8");
        // R4/R5: group masks
        step(16'h0, 1, 1, MADR, 16'hF000, 1, "R4");
        step(16'h0880, 0, 0, 0, 0, 1, "R5");
        step(16'h0, 1, 1, MADR, 16'h0F80, 1, "R5");
        step(16'h0, 0, 0, 0, 0, 1, "R5");
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ev;
            bit s, w;
            int a;
            ev = (($urandom % 6) == 0) ? 16'($urandom) : 16'h0;
            s  = ($urandom % 3) == 0;
            w  = ($urandom % 4) == 0;
            a  = ((($urandom % 2) == 0) ? (((($urandom % 2) == 0)) ? PADR : MADR) : int'($urandom % 8));
            step(ev, s, w, a, 16'($urandom), bit'($urandom % 2), "R6");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule